// File: doc/BRIEF.md
# Precise Trap Commit Unit for a Five-Stage Pipeline

This unit sits beside a five-stage in-order integer pipeline and decides when the machine traps. It keeps its own copy of every instruction slot past fetch: a valid bit, the instruction's address and a pending-fault flag with its code. A fault found in fetch, decode or execute is not acted on when it is found. It is attached to the instruction and travels with it until the instruction reaches the memory stage, which is the only commit point. At that point the unit looks at the carried fault, any data-address fault found in the memory stage, and the external interrupt line, and chooses one outcome for the cycle.

A trap writes the saved-PC and cause registers, kills every stage, blocks the writeback of the committing instruction and steers fetch to a fixed handler address. Taking a trap also masks interrupts and enters privileged mode, and saves the mode that was active before. A return-from-exception that commits without a fault does three things. It unmasks interrupts, restores the saved mode and steers fetch back to the saved PC. The younger instructions behind it are discarded.

Top module: `exc_commit`

## Requirements
- R1: While reset is held, all kill outputs, wb_suppress and redirect_valid are 0, epc is 0, cause is 0, irq_en is 1 and kernel_mode is 0 (user).
- R2: An instruction fetched with f_valid=1 in cycle t traps in cycle t+3, when it occupies the memory stage. The cause register then takes its carried code, where 1 is a fetch address fault, 2 an illegal opcode in decode, 3 an overflow in execute and 4 a data address fault in the memory stage.
- R3: When one instruction collects faults in several stages, the code of the earliest stage is the one written to cause.
- R4: With irq_en=1, irq_req=1 and a valid instruction in the memory stage, a trap is taken with cause 0, whether or not that instruction also carries a fault.
- R5: In a trap cycle all four kill outputs and wb_suppress are 1, and redirect_valid=1 with redirect_pc equal to the HANDLER_PC parameter. From the next cycle on, epc holds the PC of the trapping instruction.
- R6: The instructions younger than a trap or a return are discarded. Fault inputs raised while their stage holds a discarded slot never cause a trap.
- R7: A trap clears irq_en, sets kernel_mode to 1 and saves the previous kernel_mode.
- R8: When m_ret=1 with a valid instruction in the memory stage and no trap, kill_f, kill_d and kill_e are 1, kill_m and wb_suppress are 0, and redirect_pc equals epc. In the next cycle irq_en is 1 and kernel_mode has the saved value.
- R9: Bubbles (f_valid=0) never trap, even when fault inputs are raised for them.
- R10: While irq_en=0, irq_req has no effect on any output.
- R11: When a return and a trap fall in the same cycle, the trap is taken and the return has no effect on irq_en or kernel_mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| f_valid | input | 1 | A real instruction is being fetched this cycle |
| f_pc | input | XLEN | Address of the fetched instruction |
| f_addr_fault | input | 1 | Fetch address fault for the fetched instruction |
| d_illegal | input | 1 | Illegal opcode for the instruction in decode |
| e_overflow | input | 1 | Arithmetic overflow for the instruction in execute |
| m_data_fault | input | 1 | Data address fault for the instruction in the memory stage |
| irq_req | input | 1 | External interrupt request |
| m_ret | input | 1 | The memory-stage instruction is a return-from-exception |
| kill_f | output | 1 | Discard the fetch slot |
| kill_d | output | 1 | Discard the decode slot |
| kill_e | output | 1 | Discard the execute slot |
| kill_m | output | 1 | Discard the memory-stage slot |
| wb_suppress | output | 1 | Block writeback of the committing instruction |
| redirect_valid | output | 1 | Steer fetch to redirect_pc |
| redirect_pc | output | XLEN | Handler address or return address |
| epc | output | XLEN | Saved PC of the last trapping instruction |
| cause | output | 3 | Code of the last trap |
| irq_en | output | 1 | Interrupts enabled |
| kernel_mode | output | 1 | 1 = privileged mode |

## Verification
Two kinds of overlap at the commit point need care. An interrupt can arrive while the committing instruction carries its own fault, and a return can commit while that same instruction faults or is interrupted. The bench builds these cases by holding irq_req high across a faulting instruction and by placing m_ret on a slot that carries a fault. A behavioural model of the stages runs beside the design and is compared every cycle. It judges the case by which cause is written, whether the kill pattern is the full trap pattern or the return pattern, and whether irq_en and kernel_mode were left as the trap sets them.

// File: rtl/exc_commit.sv
module exc_commit #(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] HANDLER_PC = 'h100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            f_valid,
  input  logic [XLEN-1:0] f_pc,
  input  logic            f_addr_fault,
  input  logic            d_illegal,
  input  logic            e_overflow,
  input  logic            m_data_fault,
  input  logic            irq_req,
  input  logic            m_ret,
  output logic            kill_f,
  output logic            kill_d,
  output logic            kill_e,
  output logic            kill_m,
  output logic            wb_suppress,
  output logic            redirect_valid,
  output logic [XLEN-1:0] redirect_pc,
  output logic [XLEN-1:0] epc,
  output logic [2:0]      cause,
  output logic            irq_en,
  output logic            kernel_mode
);
  localparam logic [2:0] C_IRQ   = 3'd0;
  localparam logic [2:0] C_FETCH = 3'd1;
  localparam logic [2:0] C_ILL   = 3'd2;
  localparam logic [2:0] C_OVF   = 3'd3;
  localparam logic [2:0] C_DATA  = 3'd4;

  logic            d_v, e_v, m_v;
  logic            d_x, e_x, m_x;
  logic [2:0]      d_c, e_c, m_c;
  logic [XLEN-1:0] d_pc, e_pc, m_pc;
  logic            prev_mode;

  logic       irq_hit, sync_hit, trap, ret_take, flush;
  logic [2:0] trap_cause;

  assign irq_hit    = m_v & irq_req & irq_en;
  assign sync_hit   = m_v & (m_x | m_data_fault);
  assign trap       = irq_hit | sync_hit;
  assign ret_take   = m_v & m_ret & ~trap;
  assign flush      = trap | ret_take;
  assign trap_cause = irq_hit ? C_IRQ : (m_x ? m_c : C_DATA);

  assign kill_f         = flush;
  assign kill_d         = flush;
  assign kill_e         = flush;
  assign kill_m         = trap;
  assign wb_suppress    = trap;
  assign redirect_valid = flush;
  assign redirect_pc    = trap ? HANDLER_PC : epc;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      d_v <= 1'b0; e_v <= 1'b0; m_v <= 1'b0;
      d_x <= 1'b0; e_x <= 1'b0; m_x <= 1'b0;
    end else begin
      d_v <= f_valid;
      d_x <= f_valid & f_addr_fault;
      e_v <= d_v;
      e_x <= d_x | (d_v & d_illegal);
      m_v <= e_v;
      m_x <= e_x | (e_v & e_overflow);
    end
    d_pc <= f_pc;
    d_c  <= C_FETCH;
    e_pc <= d_pc;
    e_c  <= d_x ? d_c : C_ILL;
    m_pc <= e_pc;
    m_c  <= e_x ? e_c : C_OVF;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc         <= '0;
      cause       <= C_IRQ;
      irq_en      <= 1'b1;
      kernel_mode <= 1'b0;
      prev_mode   <= 1'b0;
    end else if (trap) begin
      epc         <= m_pc;
      cause       <= trap_cause;
      irq_en      <= 1'b0;
      prev_mode   <= kernel_mode;
      kernel_mode <= 1'b1;
    end else if (ret_take) begin
      irq_en      <= 1'b1;
      kernel_mode <= prev_mode;
    end
  end

  AST_EPC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_m && redirect_valid) |=> (epc == $past(m_pc))); // R5
  AST_IRQ_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (m_v && irq_req && irq_en) |=> (cause == C_IRQ && !irq_en && kernel_mode)); // R4
  AST_FLUSH_YOUNGER: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> (!d_v && !e_v && !m_v)); // R6
  AST_BUBBLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !m_v |-> (!redirect_valid && !wb_suppress)); // R9
  AST_MASKED_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_en && m_v && !m_x && !m_data_fault && !m_ret) |-> !redirect_valid); // R10
  AST_RET_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_valid && !kill_m) |=> (irq_en && kernel_mode == $past(prev_mode))); // R8
  AST_TRAP_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    wb_suppress |=> (!irq_en && kernel_mode && prev_mode == $past(kernel_mode))); // R7
endmodule

// File: tb/tb_exc_commit.sv
module tb_exc_commit;
  localparam logic [31:0] HPC = 32'h100;

  logic clk = 0, rst_n = 0;
  logic f_valid = 0, f_addr_fault = 0, d_illegal = 0, e_overflow = 0;
  logic m_data_fault = 0, irq_req = 0, m_ret = 0;
  logic [31:0] f_pc = 0;
  logic kill_f, kill_d, kill_e, kill_m, wb_suppress, redirect_valid;
  logic [31:0] redirect_pc, epc;
  logic [2:0] cause;
  logic irq_en, kernel_mode;

  int checks = 0, fails = 0, cyc = 0;

  int mv[3], mx[3], mc[3];
  logic [31:0] mp[3];
  logic [31:0] m_epc;
  int m_cause, m_ie, m_mode, m_pmode;

  exc_commit #(.XLEN(32), .HANDLER_PC(HPC)) dut (
    .clk(clk), .rst_n(rst_n), .f_valid(f_valid), .f_pc(f_pc),
    .f_addr_fault(f_addr_fault), .d_illegal(d_illegal), .e_overflow(e_overflow),
    .m_data_fault(m_data_fault), .irq_req(irq_req), .m_ret(m_ret),
    .kill_f(kill_f), .kill_d(kill_d), .kill_e(kill_e), .kill_m(kill_m),
    .wb_suppress(wb_suppress), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc), .epc(epc), .cause(cause),
    .irq_en(irq_en), .kernel_mode(kernel_mode));

  always #10 clk = ~clk;

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 5000 cycles", cyc);
      finish_run();
    end
  end

  task automatic step(input bit fv, input logic [31:0] pc, input bit ff, input bit ill,
                      input bit ovf, input bit df, input bit irq, input bit rt);
    bit irq_hit, sync, trap, ret_t;
    int cz;
    string tag;
    @(negedge clk);
    f_valid = fv; f_pc = pc; f_addr_fault = ff; d_illegal = ill;
    e_overflow = ovf; m_data_fault = df; irq_req = irq; m_ret = rt;
    #2;
    irq_hit = mv[2] != 0 && irq && m_ie != 0;
    sync    = mv[2] != 0 && (mx[2] != 0 || df);
    trap    = irq_hit || sync;
    ret_t   = mv[2] != 0 && rt && !trap;
    cz      = irq_hit ? 0 : (mx[2] != 0 ? mc[2] : 4);
    if (trap && rt) tag = "R11";
    else if (irq_hit) tag = "R4";
    else if (sync && mx[2] != 0 && df) tag = "R3";
    else if (sync) tag = "R2";
    else if (ret_t) tag = "R8";
    else if (irq && m_ie == 0) tag = "R10";
    else if ((ill && mv[0] == 0) || (ovf && mv[1] == 0) || (df && mv[2] == 0)) tag = "R6";
    else tag = "R9";
    chk(trap ? "R5" : tag, "kill", {kill_f, kill_d, kill_e, kill_m}, trap ? 4'hF : (ret_t ? 4'hE : 4'h0));
    chk(trap ? "R5" : tag, "wb_suppress", wb_suppress, trap);
    chk(trap ? "R5" : tag, "redirect_valid", redirect_valid, trap || ret_t);
    if (trap || ret_t) chk(trap ? "R5" : "R8", "redirect_pc", redirect_pc, trap ? HPC : m_epc);
    chk(tag, "epc", epc, m_epc);
    chk(tag, "cause", cause, m_cause);
    chk(tag, "irq_en", irq_en, m_ie);
    chk(tag, "kernel_mode", kernel_mode, m_mode);
    @(posedge clk); #1;
    if (trap) begin
      m_epc = mp[2]; m_cause = cz; m_pmode = m_mode; m_mode = 1; m_ie = 0;
    end else if (ret_t) begin
      m_ie = 1; m_mode = m_pmode;
    end
    if (trap || ret_t) begin
      for (int i = 0; i < 3; i++) begin mv[i] = 0; mx[i] = 0; end
    end else begin
      mv[2] = mv[1]; mp[2] = mp[1];
      mc[2] = mx[1] != 0 ? mc[1] : 3;
      mx[2] = (mx[1] != 0 || (mv[1] != 0 && ovf)) ? 1 : 0;
      mv[1] = mv[0]; mp[1] = mp[0];
      mc[1] = mx[0] != 0 ? mc[0] : 2;
      mx[1] = (mx[0] != 0 || (mv[0] != 0 && ill)) ? 1 : 0;
      mv[0] = fv; mp[0] = pc; mx[0] = (fv && ff) ? 1 : 0; mc[0] = 1;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin mv[i] = 0; mx[i] = 0; mc[i] = 0; mp[i] = 0; end
    m_epc = 0; m_cause = 0; m_ie = 1; m_mode = 0; m_pmode = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); #2;
    chk("R1", "kill", {kill_f, kill_d, kill_e, kill_m}, 4'h0);
    chk("R1", "wb/redirect", {wb_suppress, redirect_valid}, 2'b00);
    chk("R1", "epc", epc, 0);
    chk("R1", "cause", cause, 0);
    chk("R1", "ie/mode", {irq_en, kernel_mode}, 2'b10);
    @(posedge clk); #1; rst_n = 1;

    for (int i = 0; i < 6; i++) step(1, 32'h10 + 4 * i, 0, 0, 0, 0, 0, 0);
    // R9: bubbles with fault inputs raised
    step(0, 32'h30, 1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 0, 0);
    idle(2);

    // R2: fetch fault traps three cycles later
    step(1, 32'h40, 1, 0, 0, 0, 0, 0);
    idle(3);
    chk("R2", "cause", cause, 1);
    chk("R2", "epc", epc, 32'h40);
    chk("R7", "ie/mode", {irq_en, kernel_mode}, 2'b01);

    // R8: return restores user mode and interrupts
    step(1, 32'h200, 0, 0, 0, 0, 0, 0);
    idle(2);
    step(0, 0, 0, 0, 0, 0, 0, 1);
    chk("R8", "ie/mode", {irq_en, kernel_mode}, 2'b10);

    // R3 and R6: faults in every stage, younger slots flushed
    step(1, 32'h80, 1, 0, 0, 0, 0, 0);
    step(1, 32'h84, 0, 1, 0, 0, 0, 0);
    step(1, 32'h88, 0, 0, 1, 0, 0, 0);
    step(1, 32'h8C, 1, 1, 1, 1, 0, 0);
    chk("R3", "cause", cause, 1);
    chk("R3", "epc", epc, 32'h80);
    step(0, 0, 0, 1, 1, 1, 0, 0);
    step(0, 0, 0, 1, 1, 1, 0, 0);
    chk("R6", "epc after flush", epc, 32'h80);
    step(1, 32'h300, 0, 0, 0, 0, 0, 0);
    idle(2);
    step(0, 0, 0, 0, 0, 0, 0, 1);

    // illegal-only and overflow-only and data-only
    step(1, 32'h90, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 0, 0);
    idle(2);
    chk("R2", "cause illegal", cause, 2);
    step(1, 32'h304, 0, 0, 0, 0, 0, 0); idle(2); step(0, 0, 0, 0, 0, 0, 0, 1);
    step(1, 32'hA0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    chk("R2", "cause overflow", cause, 3);
    step(1, 32'h308, 0, 0, 0, 0, 0, 0); idle(2); step(0, 0, 0, 0, 0, 0, 0, 1);
    step(1, 32'hB0, 0, 0, 0, 0, 0, 0); idle(2);
    step(0, 0, 0, 0, 0, 1, 0, 0);
    chk("R2", "cause data", cause, 4);
    step(1, 32'h30C, 0, 0, 0, 0, 0, 0); idle(2); step(0, 0, 0, 0, 0, 0, 0, 1);

    // R4: interrupt overrides an overflow on the committing instruction
    step(1, 32'hC0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1, 0);
    chk("R4", "cause", cause, 0);
    chk("R4", "epc", epc, 32'hC0);

    // R10: masked interrupt held over a stream
    for (int i = 0; i < 8; i++) step(1, 32'h400 + 4 * i, 0, 0, 0, 0, 1, 0);
    chk("R10", "epc unchanged", epc, 32'hC0);

    // R11: return carrying a data fault traps instead
    step(1, 32'h500, 0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 1, 1, 1);
    chk("R11", "cause", cause, 4);
    chk("R11", "ie/mode", {irq_en, kernel_mode}, 2'b01);
    step(1, 32'h504, 0, 0, 0, 0, 0, 0); idle(2); step(0, 0, 0, 0, 0, 0, 0, 1);
    // R11: interrupt and return together
    step(1, 32'h600, 0, 0, 0, 0, 0, 0); idle(2);
    step(0, 0, 0, 0, 0, 0, 1, 1);
    chk("R11", "cause irq", cause, 0);
    chk("R11", "epc", epc, 32'h600);
    idle(3);
    finish_run();
  end
endmodule